// File: doc/BRIEF.md
# Shared Interrupt Router

This block sits between peripheral interrupt sources and a system interrupt controller. Each slot has four interrupt pins, and each pin can be steered through one of four shared routing entries. Up to three auxiliary sources, plus events that name a system line directly, also feed the block. Each routing entry picks one of sixteen system lines and selects edge or level behaviour. For level behaviour the block keeps a holder mask for each line, so a line that several sources share goes inactive only after the last of those sources has released it.

Events arrive as a valid/ready stream, one per clock. Each event is an assert or a clear and names its source. The block turns each event into zero or one controller commands: raise a level, pulse an edge, or clear. Commands leave on a valid/ready stream held in a single output register. When `cmd_ready` is low and that register is full, `ev_ready` falls and the event stream waits. Routing is configured through a plain write port that takes effect on the next clock. A `hard_rst` pulse empties every holder mask. The block then sends one clear for each line that was held, lowest line first. No events are accepted while that sweep runs.

Top module: `irq_router`

## Requirements
- R1: After `rst_n`, `cmd_valid` is 0 and `ev_ready` is 1. Every slot pin code is 0. All four routing entries target an out-of-range line in level mode. Every auxiliary source is disabled, so no event produces a command until configuration is written.
- R2: A slot pin code of 0 means the pin is unrouted, and events on that pin are ignored. A code c from 1 to 7 selects routing entry (c-1) mod 4. Codes are written with `cfg_target`=0, `cfg_index`=slot, `cfg_pin`=pin (0..3), and `cfg_data[2:0]`=code.
- R3: A target line value of 16 or more disables a route, and events that resolve to it are dropped. This covers routing entries (`cfg_target`=1, `cfg_data`=line, `cfg_flag`=1 for level) and auxiliary sources (`cfg_target`=2, `cfg_data`=line, `cfg_flag`=enable), including any value with bit 7 set.
- R4: Level assert: if the source already holds its line, the event is ignored. Otherwise the source's holder bit is set, and a RAISE command (`cmd_op`=1) is sent only if the line had no holder before.
- R5: Edge assert always sends a PULSE command (`cmd_op`=2) and records no holder.
- R6: Level clear: if the source does not hold the line, the event is ignored. Otherwise its holder bit is removed, and a CLEAR command (`cmd_op`=3) is sent only when no holder remains.
- R7: Edge clear always sends a CLEAR for its line at once.
- R8: Auxiliary source n (`ev_kind`=1) is used only when it is enabled, and it holds with bit 30+n. A direct event (`ev_kind`=2) targets line `ev_src[3:0]` and holds with bit 29. Both kinds take the level/edge choice from `ev_level`. Slot events (`ev_kind`=0) hold with the slot number as the bit and take the mode from their routing entry.
- R9: A `hard_rst` pulse empties every holder mask. It then sends one CLEAR for each line that was held, in ascending line order. `ev_ready` stays low from that cycle until the last such CLEAR has been loaded.
- R10: A command appears on `cmd_*` in the cycle after its event is accepted. While `cmd_valid` is high and `cmd_ready` is low, the command stays stable.
- R11: `ev_ready` is low whenever the output register is full and `cmd_ready` is low.
- R12: A slot event whose index is not below NUM_SLOTS (at most 29) is dropped. An auxiliary event whose index is not below NUM_AUX is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_rst | input | 1 | One-cycle request to drop all holders and clear held lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | 0 slot pin code, 1 routing entry, 2 auxiliary source |
| cfg_index | input | SRC_W | Slot, entry or auxiliary index |
| cfg_pin | input | 2 | Pin of the slot for pin-code writes |
| cfg_data | input | TGT_W | Pin code or target line |
| cfg_flag | input | 1 | Level mode (entry) or enable (auxiliary) |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted on this clock when valid |
| ev_kind | input | 2 | 0 slot, 1 auxiliary, 2 direct line |
| ev_assert | input | 1 | 1 assert, 0 clear |
| ev_src | input | SRC_W | Source index or line number |
| ev_pin | input | 2 | Slot pin 0..3 |
| ev_level | input | 1 | Level mode for auxiliary and direct events |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_op | output | 2 | 1 RAISE, 2 PULSE, 3 CLEAR |
| cmd_line | output | LINE_W | System line of the command |

## Verification
The properties assume that `hard_rst` is a single-cycle pulse and that `cmd_ready` is driven to a known value. They also assume that event fields stay unchanged while `ev_valid` waits for `ev_ready`. The bench keeps to these assumptions: a single driver task holds each event until it sees `ev_ready` at a falling edge, and it raises `hard_rst` for exactly one cycle. `cmd_ready` changes only just after a rising edge. The bench also never writes configuration while an event that depends on it is in flight.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

  localparam int NUM_ROUTES = 4;
  localparam int PIN_W      = 3;
  localparam int HB_LINE    = 29;
  localparam int HB_AUX0    = 30;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RAISE = 2'd1,
    OP_PULSE = 2'd2,
    OP_CLEAR = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    EV_SLOT = 2'd0,
    EV_AUX  = 2'd1,
    EV_LINE = 2'd2
  } ev_kind_e;

  typedef enum logic [1:0] {
    CFG_PIN   = 2'd0,
    CFG_ROUTE = 2'd1,
    CFG_AUX   = 2'd2
  } cfg_tgt_e;

endpackage

// File: rtl/irq_rt_cfg.sv
module irq_rt_cfg
  import irq_rt_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_AUX   = 3,
  parameter int LINES     = 16,
  parameter int TGT_W     = 8,
  parameter int SRC_W     = 5,
  parameter int LINE_W    = 4,
  parameter int HB_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_target,
  input  logic [SRC_W-1:0]  cfg_index,
  input  logic [1:0]        cfg_pin,
  input  logic [TGT_W-1:0]  cfg_data,
  input  logic              cfg_flag,
  input  logic [1:0]        ev_kind,
  input  logic [SRC_W-1:0]  ev_src,
  input  logic [1:0]        ev_pin,
  input  logic              ev_level,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_line,
  output logic              lk_level,
  output logic [HB_W-1:0]   lk_bit
);

  localparam int SLOT_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int AUX_IW  = (NUM_AUX > 1) ? $clog2(NUM_AUX) : 1;
  localparam logic [TGT_W-1:0] OFF_LINE = {TGT_W{1'b1}};

  logic [PIN_W-1:0] pin_q [NUM_SLOTS][NUM_ROUTES];
  logic [TGT_W-1:0] rline_q [NUM_ROUTES];
  logic             rlvl_q  [NUM_ROUTES];
  logic [TGT_W-1:0] aline_q [NUM_AUX];
  logic             aen_q   [NUM_AUX];

  logic cfg_slot_ok, cfg_aux_ok;
  assign cfg_slot_ok = cfg_index < SRC_W'(NUM_SLOTS);
  assign cfg_aux_ok  = cfg_index < SRC_W'(NUM_AUX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int p = 0; p < NUM_ROUTES; p++)
          pin_q[s][p] <= '0;
      for (int r = 0; r < NUM_ROUTES; r++) begin
        rline_q[r] <= OFF_LINE;
        rlvl_q[r]  <= 1'b1;
      end
      for (int a = 0; a < NUM_AUX; a++) begin
        aline_q[a] <= OFF_LINE;
        aen_q[a]   <= 1'b0;
      end
    end else if (cfg_we) begin
      unique case (cfg_tgt_e'(cfg_target))
        CFG_PIN:
          if (cfg_slot_ok)
            pin_q[cfg_index[SLOT_IW-1:0]][cfg_pin] <= cfg_data[PIN_W-1:0];
        CFG_ROUTE:
          if (cfg_index < SRC_W'(NUM_ROUTES)) begin
            rline_q[cfg_index[1:0]] <= cfg_data;
            rlvl_q[cfg_index[1:0]]  <= cfg_flag;
          end
        CFG_AUX:
          if (cfg_aux_ok) begin
            aline_q[cfg_index[AUX_IW-1:0]] <= cfg_data;
            aen_q[cfg_index[AUX_IW-1:0]]   <= cfg_flag;
          end
        default: ;
      endcase
    end
  end

  logic [PIN_W-1:0] code, code_m1;
  logic [1:0]       ent;
  logic [TGT_W-1:0] tgt;

  always_comb begin
    lk_hit   = 1'b0;
    lk_level = 1'b0;
    lk_bit   = '0;
    code     = '0;
    code_m1  = '0;
    ent      = '0;
    tgt      = OFF_LINE;
    unique case (ev_kind_e'(ev_kind))
      EV_SLOT:
        if (ev_src < SRC_W'(NUM_SLOTS)) begin
          code = pin_q[ev_src[SLOT_IW-1:0]][ev_pin];
          if (code != '0) begin
            code_m1  = code - PIN_W'(1);
            ent      = code_m1[1:0];
            tgt      = rline_q[ent];
            lk_hit   = tgt < TGT_W'(LINES);
            lk_level = rlvl_q[ent];
            lk_bit   = HB_W'(ev_src);
          end
        end
      EV_AUX:
        if (ev_src < SRC_W'(NUM_AUX)) begin
          tgt      = aline_q[ev_src[AUX_IW-1:0]];
          lk_hit   = aen_q[ev_src[AUX_IW-1:0]] && (tgt < TGT_W'(LINES));
          lk_level = ev_level;
          lk_bit   = HB_W'(HB_AUX0) + HB_W'(ev_src);
        end
      EV_LINE: begin
        tgt      = TGT_W'(ev_src[LINE_W-1:0]);
        lk_hit   = 1'b1;
        lk_level = ev_level;
        lk_bit   = HB_W'(HB_LINE);
      end
      default: ;
    endcase
  end

  assign lk_line = tgt[LINE_W-1:0];

endmodule

// File: rtl/irq_rt_hold.sv
module irq_rt_hold #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4,
  parameter int HOLD_W = 33,
  parameter int HB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              upd_en,
  input  logic              upd_set,
  input  logic [LINE_W-1:0] upd_line,
  input  logic [HB_W-1:0]   upd_bit,
  input  logic [LINE_W-1:0] rd_line,
  output logic [HOLD_W-1:0] rd_mask,
  output logic [LINES-1:0]  held
);

  logic [HOLD_W-1:0] mask_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) mask_q[l] <= '0;
    end else if (wipe) begin
      for (int l = 0; l < LINES; l++) mask_q[l] <= '0;
    end else if (upd_en) begin
      mask_q[upd_line][upd_bit] <= upd_set;
    end
  end

  assign rd_mask = mask_q[rd_line];

  for (genvar g = 0; g < LINES; g++) begin : g_held
    assign held[g] = |mask_q[g];
  end

endmodule

// File: rtl/irq_rt_sweep.sv
module irq_rt_sweep #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINES-1:0]  load_vec,
  input  logic              pop,
  output logic              busy,
  output logic [LINE_W-1:0] pick
);

  logic [LINES-1:0] pend_q;

  always_comb begin
    pick = '0;
    for (int l = LINES - 1; l >= 0; l--)
      if (pend_q[l]) pick = LINE_W'(l);
  end

  assign busy = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else if (load)
      pend_q <= pend_q | load_vec;
    else if (pop)
      pend_q[pick] <= 1'b0;
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_AUX   = 3,
  parameter int LINES     = 16,
  parameter int TGT_W     = 8,
  parameter int SRC_W     = 5,
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_target,
  input  logic [SRC_W-1:0]  cfg_index,
  input  logic [1:0]        cfg_pin,
  input  logic [TGT_W-1:0]  cfg_data,
  input  logic              cfg_flag,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic              ev_assert,
  input  logic [SRC_W-1:0]  ev_src,
  input  logic [1:0]        ev_pin,
  input  logic              ev_level,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [LINE_W-1:0] cmd_line
);

  localparam int HOLD_W = HB_AUX0 + NUM_AUX;
  localparam int HB_W   = $clog2(HOLD_W);

  logic              lk_hit, lk_level;
  logic [LINE_W-1:0] lk_line;
  logic [HB_W-1:0]   lk_bit;
  logic [HOLD_W-1:0] rd_mask, rest_mask;
  logic [LINES-1:0]  held;
  logic              sweep_busy, pop;
  logic [LINE_W-1:0] sweep_pick;
  logic              upd_en, upd_set;
  logic              out_free, acc, ld, nv, has_bit;
  cmd_op_e           nop;
  logic [LINE_W-1:0] nline;
  logic              cmd_valid_q;
  cmd_op_e           cmd_op_q;
  logic [LINE_W-1:0] cmd_line_q;

  irq_rt_cfg #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_AUX(NUM_AUX), .LINES(LINES), .TGT_W(TGT_W),
    .SRC_W(SRC_W), .LINE_W(LINE_W), .HB_W(HB_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
    .cfg_index(cfg_index), .cfg_pin(cfg_pin), .cfg_data(cfg_data),
    .cfg_flag(cfg_flag), .ev_kind(ev_kind), .ev_src(ev_src), .ev_pin(ev_pin),
    .ev_level(ev_level), .lk_hit(lk_hit), .lk_line(lk_line),
    .lk_level(lk_level), .lk_bit(lk_bit)
  );

  irq_rt_hold #(
    .LINES(LINES), .LINE_W(LINE_W), .HOLD_W(HOLD_W), .HB_W(HB_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .wipe(hard_rst), .upd_en(upd_en),
    .upd_set(upd_set), .upd_line(lk_line), .upd_bit(lk_bit),
    .rd_line(lk_line), .rd_mask(rd_mask), .held(held)
  );

  irq_rt_sweep #(
    .LINES(LINES), .LINE_W(LINE_W)
  ) u_sweep (
    .clk(clk), .rst_n(rst_n), .load(hard_rst), .load_vec(held), .pop(pop),
    .busy(sweep_busy), .pick(sweep_pick)
  );

  assign out_free  = !cmd_valid_q || cmd_ready;
  assign ev_ready  = out_free && !sweep_busy && !hard_rst;
  assign acc       = ev_valid && ev_ready;
  assign has_bit   = rd_mask[lk_bit];
  assign rest_mask = rd_mask & ~(HOLD_W'(1) << lk_bit);

  always_comb begin
    nv      = 1'b0;
    nop     = OP_NONE;
    nline   = lk_line;
    pop     = 1'b0;
    upd_en  = 1'b0;
    upd_set = 1'b0;
    if (sweep_busy && !hard_rst && out_free) begin
      nv    = 1'b1;
      nop   = OP_CLEAR;
      nline = sweep_pick;
      pop   = 1'b1;
    end else if (acc && lk_hit) begin
      unique case ({ev_assert, lk_level})
        2'b11: if (!has_bit) begin
          upd_en  = 1'b1;
          upd_set = 1'b1;
          nv      = (rd_mask == '0);
          nop     = OP_RAISE;
        end
        2'b10: begin
          nv  = 1'b1;
          nop = OP_PULSE;
        end
        2'b01: if (has_bit) begin
          upd_en = 1'b1;
          nv     = (rest_mask == '0);
          nop    = OP_CLEAR;
        end
        default: begin
          nv  = 1'b1;
          nop = OP_CLEAR;
        end
      endcase
    end
  end

  assign ld = out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_NONE;
      cmd_line_q  <= '0;
    end else if (ld) begin
      cmd_valid_q <= nv;
      if (nv) begin
        cmd_op_q   <= nop;
        cmd_line_q <= nline;
      end
    end
  end

  assign cmd_valid = cmd_valid_q;
  assign cmd_op    = cmd_op_q;
  assign cmd_line  = cmd_line_q;

endmodule

// File: rtl/irq_rt_chk.sv
module irq_rt_chk #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hard_rst,
  input logic              ev_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [LINE_W-1:0] cmd_line,
  input logic              sweep_busy,
  input logic [LINES-1:0]  held,
  input logic              ld,
  input logic              nv,
  input logic [1:0]        nop,
  input logic [LINE_W-1:0] nline
);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_line)));

  p_full_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |-> !ev_ready);

  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (held == '0));

  p_sweep_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_rst || sweep_busy) |-> !ev_ready);

  p_raise_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && nv && nop == 2'd1) |-> !held[nline]);

  p_raise_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && nv && nop == 2'd1) |=> held[cmd_line]);

endmodule

bind irq_router irq_rt_chk #(.LINES(LINES), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .ev_ready(ev_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_line(cmd_line), .sweep_busy(sweep_busy), .held(held), .ld(ld),
  .nv(nv), .nop(nop), .nline(nline)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NA = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hard_rst = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_target = '0;
  logic [4:0] cfg_index = '0;
  logic [1:0] cfg_pin = '0;
  logic [7:0] cfg_data = '0;
  logic cfg_flag = 1'b0;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic [1:0] ev_kind = '0;
  logic ev_assert = 1'b0;
  logic [4:0] ev_src = '0;
  logic [1:0] ev_pin = '0;
  logic ev_level = 1'b0;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic [1:0] cmd_op;
  logic [3:0] cmd_line;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .cfg_we(cfg_we),
    .cfg_target(cfg_target), .cfg_index(cfg_index), .cfg_pin(cfg_pin),
    .cfg_data(cfg_data), .cfg_flag(cfg_flag), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_assert(ev_assert),
    .ev_src(ev_src), .ev_pin(ev_pin), .ev_level(ev_level),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_line(cmd_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] exp_op_q[$];
  logic [3:0] exp_line_q[$];
  string      exp_req_q[$];

  int         m_pin [NS][4];
  int         m_rline [4];
  bit         m_rlvl [4];
  int         m_aline [NA];
  bit         m_aen [NA];
  logic [32:0] m_hold [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] op, input int line, input string req);
    exp_op_q.push_back(op);
    exp_line_q.push_back(4'(line));
    exp_req_q.push_back(req);
  endtask

  // monitor: scoreboard pop on every transfer
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_op_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected command line", int'(cmd_line), -1);
      end else begin
        logic [1:0] eo;
        logic [3:0] el;
        string      er;
        eo = exp_op_q.pop_front();
        el = exp_line_q.pop_front();
        er = exp_req_q.pop_front();
        chk(cmd_op == eo, er, "command op", int'(cmd_op), int'(eo));
        chk(cmd_line == el, er, "command line", int'(cmd_line), int'(el));
      end
    end
  end

  task automatic cfg_write(input int tgt, input int idx, input int pin,
                           input int data, input bit flag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_target = 2'(tgt); cfg_index = 5'(idx);
    cfg_pin = 2'(pin); cfg_data = 8'(data); cfg_flag = flag;
    if (tgt == 0 && idx < NS) m_pin[idx][pin] = data % 8;
    if (tgt == 1 && idx < 4) begin m_rline[idx] = data; m_rlvl[idx] = flag; end
    if (tgt == 2 && idx < NA) begin m_aline[idx] = data; m_aen[idx] = flag; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int kind, input bit asrt, input int src, input int pin,
                      input bit lvl, input string req);
    bit hit, mlvl, prod;
    int line, hb, pre;
    logic [1:0] op;
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 2'(kind); ev_assert = asrt;
    ev_src = 5'(src); ev_pin = 2'(pin); ev_level = lvl;
    while (!ev_ready) @(negedge clk);
    hit = 1'b0; mlvl = 1'b0; line = 0; hb = 0; prod = 1'b0; op = 2'd0;
    if (kind == 0) begin
      if (src < NS && m_pin[src][pin] != 0) begin
        int e;
        e = (m_pin[src][pin] - 1) % 4;
        if (m_rline[e] < 16) begin
          hit = 1'b1; line = m_rline[e]; mlvl = m_rlvl[e]; hb = src;
        end
      end
    end else if (kind == 1) begin
      if (src < NA && m_aen[src] && m_aline[src] < 16) begin
        hit = 1'b1; line = m_aline[src]; mlvl = lvl; hb = 30 + src;
      end
    end else begin
      hit = 1'b1; line = src % 16; mlvl = lvl; hb = 29;
    end
    if (hit) begin
      if (asrt && mlvl) begin
        if (!m_hold[line][hb]) begin
          if (m_hold[line] == '0) begin prod = 1'b1; op = 2'd1; end
          m_hold[line][hb] = 1'b1;
        end
      end else if (asrt) begin
        prod = 1'b1; op = 2'd2;
      end else if (mlvl) begin
        if (m_hold[line][hb]) begin
          m_hold[line][hb] = 1'b0;
          if (m_hold[line] == '0) begin prod = 1'b1; op = 2'd3; end
        end
      end else begin
        prod = 1'b1; op = 2'd3;
      end
    end
    pre = exp_op_q.size();
    if (prod) push(op, line, req);
    @(negedge clk);
    ev_valid = 1'b0;
    if (prod && pre == 0 && cmd_ready)
      chk(cmd_valid, "R10", "one-cycle latency valid", int'(cmd_valid), 1);
  endtask

  task automatic expect_idle(input string req);
    repeat (3) @(negedge clk);
    chk(exp_op_q.size() == 0 && !cmd_valid, req, "no command expected",
        int'(cmd_valid), 0);
  endtask

  task automatic do_hard_reset(input string req);
    int n;
    n = 0;
    @(negedge clk);
    hard_rst = 1'b1;
    for (int l = 0; l < 16; l++) begin
      if (m_hold[l] != '0) begin push(2'd3, l, req); n++; end
      m_hold[l] = '0;
    end
    #1;
    chk(!ev_ready, req, "ev_ready during hard reset", int'(ev_ready), 0);
    @(negedge clk);
    hard_rst = 1'b0;
    #1;
    if (n > 1) chk(!ev_ready, req, "ev_ready during sweep", int'(ev_ready), 0);
  endtask

  task automatic set_ready(input bit v);
    @(posedge clk);
    #1 cmd_ready = v;
  endtask

  initial begin
    for (int s = 0; s < NS; s++) for (int p = 0; p < 4; p++) m_pin[s][p] = 0;
    for (int r = 0; r < 4; r++) begin m_rline[r] = 255; m_rlvl[r] = 1'b1; end
    for (int a = 0; a < NA; a++) begin m_aline[a] = 255; m_aen[a] = 1'b0; end
    for (int l = 0; l < 16; l++) m_hold[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    chk(ev_ready, "R1", "ev_ready after reset", int'(ev_ready), 1);

    // R1: routed pin but routing entries still disabled, aux disabled
    cfg_write(0, 0, 0, 1, 1'b0);
    send(0, 1'b1, 0, 0, 1'b0, "R1");
    send(1, 1'b1, 0, 0, 1'b1, "R1");
    expect_idle("R1");

    // routing setup
    cfg_write(1, 0, 0, 5, 1'b1);
    cfg_write(1, 1, 0, 9, 1'b0);
    cfg_write(1, 2, 0, 20, 1'b1);
    cfg_write(1, 3, 0, 5, 1'b1);
    cfg_write(0, 1, 0, 4, 1'b0);
    cfg_write(0, 2, 1, 2, 1'b0);
    cfg_write(0, 3, 2, 3, 1'b0);
    cfg_write(0, 4, 3, 5, 1'b0);

    // R4 / R6: sharing on line 5
    send(0, 1'b1, 0, 0, 1'b0, "R4");
    send(0, 1'b1, 0, 0, 1'b0, "R4");
    send(0, 1'b1, 1, 0, 1'b0, "R4");
    expect_idle("R4");
    send(0, 1'b0, 0, 0, 1'b0, "R6");
    send(0, 1'b0, 0, 0, 1'b0, "R6");
    expect_idle("R6");
    send(0, 1'b0, 1, 0, 1'b0, "R6");

    // R5 / R7: edge entry on line 9
    send(0, 1'b1, 2, 1, 1'b0, "R5");
    send(0, 1'b1, 2, 1, 1'b0, "R5");
    send(0, 1'b0, 2, 1, 1'b0, "R7");

    // R3 / R2 / R12 drops
    send(0, 1'b1, 3, 2, 1'b0, "R3");
    send(0, 1'b1, 5, 0, 1'b0, "R2");
    send(0, 1'b1, 9, 0, 1'b0, "R12");
    expect_idle("R12");

    // R2: code 5 wraps to entry 0
    send(0, 1'b1, 4, 3, 1'b0, "R2");

    // R8 auxiliary and direct
    cfg_write(2, 0, 0, 7, 1'b1);
    cfg_write(2, 1, 0, 8'h85, 1'b1);
    cfg_write(2, 2, 0, 3, 1'b0);
    send(1, 1'b1, 0, 0, 1'b1, "R8");
    send(1, 1'b1, 1, 0, 1'b1, "R3");
    send(1, 1'b1, 2, 0, 1'b1, "R8");
    send(1, 1'b1, 3, 0, 1'b1, "R12");
    send(2, 1'b1, 7, 0, 1'b1, "R8");
    send(1, 1'b0, 0, 0, 1'b1, "R8");
    expect_idle("R8");
    send(2, 1'b0, 7, 0, 1'b1, "R8");
    send(1, 1'b1, 0, 0, 1'b0, "R5");
    send(1, 1'b0, 0, 0, 1'b0, "R7");

    // R10 / R11 back-pressure
    set_ready(1'b0);
    send(2, 1'b1, 2, 0, 1'b0, "R10");
    chk(!ev_ready, "R11", "ev_ready while output full", int'(ev_ready), 0);
    chk(cmd_valid && cmd_op == 2'd2 && cmd_line == 4'd2, "R10", "held command line",
        int'(cmd_line), 2);
    repeat (3) @(negedge clk);
    chk(cmd_valid && cmd_op == 2'd2 && cmd_line == 4'd2, "R10", "stable under stall",
        int'(cmd_line), 2);
    set_ready(1'b1);

    // R9 hard reset: lines 5 (slot 4), 7, 12 held
    send(1, 1'b1, 0, 0, 1'b1, "R9");
    send(2, 1'b1, 12, 0, 1'b1, "R9");
    do_hard_reset("R9");
    send(0, 1'b1, 4, 3, 1'b0, "R9");
    send(0, 1'b0, 4, 3, 1'b0, "R9");
    expect_idle("R9");

    repeat (5) @(negedge clk);
    chk(exp_op_q.size() == 0, "R10", "scoreboard drained", exp_op_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule